// File: doc/BRIEF.md
# Periodic Countdown Timer with Self-Releasing Interrupt

This block is the fixed-period timer of a real-time-clock register file. Software loads a 12-bit start value and picks one of four tick sources: a 4096 Hz strobe, a 64 Hz strobe, the once-per-second clock update or the once-per-minute clock update. It then sets the enable bit. The counter steps down by one on each selected tick. When it passes from 1 to 0 it raises a sticky flag and loads the start value again, so events repeat every start-value ticks.

If the interrupt-enable bit is set, each event also pulls an active-low, open-drain-style request line. The line releases itself after a fixed hold time, counted on the free-running 4096 Hz strobe. The hold time is short for the fastest source and long for all the others. Software clears the flag by writing 0 to it. That write has no effect on the request line.

A halt input models the clock's stop/reset condition. While halt is high, only the 4096 Hz source keeps counting. Any other source is frozen. All register access goes through a byte-wide port whose read data is registered.

Top module: `rtc_cycle_timer`

## Requirements
- R1: After a synchronous reset, all four registers read 0 and the request line is released (irq_oe=0, irq_lvl=1).
- R2: The start value is split across two registers. Address 0 holds bits 7:0. Address 1 holds bits 11:8 in its bits 3:0, and its bits 7:4 always read 0. Address 2 is control: bits 1:0 are the source select, bit 4 is enable, bit 5 is interrupt enable, and its other bits read 0. Address 3 bit 0 is the flag. reg_rdata shows the addressed register one clock after reg_addr is applied.
- R3: The source select picks the tick: 00 is tick_4k, 01 is tick_64, 10 is tick_sec and 11 is tick_min. For the second and minute sources, the count step and any interrupt follow the clock edge on which that update strobe is high.
- R4: While enabled, the count drops by one per selected tick. The tick that takes it from 1 to 0 is an event and reloads the start value in place of 0, so events recur every start-value ticks.
- R5: A write that changes enable from 0 to 1 loads the start value, even if a tick arrives in the same cycle. Clearing enable freezes the count.
- R6: An event sets the flag on the next clock. Only a write of 0 to bit 0 of address 3 clears it, and writing 1 leaves it unchanged. If an event and a clearing write fall in the same cycle, the flag ends at 1.
- R7: With interrupt enable at 1, an event makes irq_oe go to 1 and irq_lvl go to 0 on the next clock. With interrupt enable at 0, an event leaves the line untouched.
- R8: The request line releases after 1 tick_4k strobe when source 00 was selected at the event, and after 32 tick_4k strobes for any other source. A new event restarts the hold. Clearing the flag does not release the line.
- R9: While halt is 1, sources 01, 10 and 11 neither count nor produce events. Source 00 keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_4k | input | 1 | 4096 Hz strobe, one clock wide |
| tick_64 | input | 1 | 64 Hz strobe, one clock wide |
| tick_sec | input | 1 | Seconds-update strobe |
| tick_min | input | 1 | Minutes-update strobe |
| halt | input | 1 | Stop/reset condition of the clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_oe | output | 1 | Request line driver enable (1 = pulling low) |
| irq_lvl | output | 1 | Request line level (0 while asserted) |

## Verification
Two things can land in one clock: a terminal count that sets the flag, and a software write of 0 that clears it. The bench provokes this by writing 0 to the status register every few cycles while short start values run on fast sources. The two streams drift against each other, so some writes land exactly on event cycles. The flag value read back, and the request line, are compared every clock against a behavioural model in which the event wins. A second pairing is also exercised: a new event arriving on the same clock as the tick_4k strobe that would have ended the hold. The model restarts the hold in that case.

// File: rtl/rtc_tmr_pkg.sv
package rtc_tmr_pkg;
  typedef enum logic [1:0] {
    A_PRE_LO = 2'd0,
    A_PRE_HI = 2'd1,
    A_CTRL   = 2'd2,
    A_STAT   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_4K  = 2'd0,
    SRC_64  = 2'd1,
    SRC_SEC = 2'd2,
    SRC_MIN = 2'd3
  } src_sel_e;

  localparam int CTRL_EN_BIT = 4;
  localparam int CTRL_IE_BIT = 5;
  localparam int STAT_FLAG_BIT = 0;
endpackage

// File: rtl/rtc_tmr_regs.sv
module rtc_tmr_regs
  import rtc_tmr_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              event_in,
  output logic [CNT_W-1:0]  preset,
  output logic [1:0]        sel,
  output logic              en,
  output logic              ie,
  output logic              flag,
  output logic              en_rise,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic wr_lo, wr_hi, wr_ctrl, wr_stat;
  logic [DATA_W-1:0] rd_mux;

  assign wr_lo   = wr && (addr == A_PRE_LO);
  assign wr_hi   = wr && (addr == A_PRE_HI);
  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_stat = wr && (addr == A_STAT);
  assign en_rise = wr_ctrl && wdata[CTRL_EN_BIT] && !en;

  always_ff @(posedge clk) begin
    if (rst) begin
      preset <= '0;
      sel    <= SRC_4K;
      en     <= 1'b0;
      ie     <= 1'b0;
    end else begin
      if (wr_lo) preset[DATA_W-1:0] <= wdata;
      if (wr_hi) preset[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      if (wr_ctrl) begin
        sel <= wdata[1:0];
        en  <= wdata[CTRL_EN_BIT];
        ie  <= wdata[CTRL_IE_BIT];
      end
    end
  end

  // event has priority over a clearing write
  always_ff @(posedge clk) begin
    if (rst)                                flag <= 1'b0;
    else if (event_in)                      flag <= 1'b1;
    else if (wr_stat && !wdata[STAT_FLAG_BIT]) flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_PRE_LO: rd_mux = preset[DATA_W-1:0];
      A_PRE_HI: rd_mux = {{PAD_W{1'b0}}, preset[CNT_W-1:DATA_W]};
      A_CTRL: begin
        rd_mux[1:0]         = sel;
        rd_mux[CTRL_EN_BIT] = en;
        rd_mux[CTRL_IE_BIT] = ie;
      end
      A_STAT: rd_mux[STAT_FLAG_BIT] = flag;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_tmr_src.sv
module rtc_tmr_src
  import rtc_tmr_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0]         ticks,
  input  logic [$clog2(N_SRC)-1:0] sel,
  input  logic                     halt,
  output logic                     tick_eff,
  output logic                     long_hold
);
  logic [N_SRC-1:0] gated;

  // only source 0 survives a halt
  for (genvar i = 0; i < N_SRC; i++) begin : g_gate
    if (i == 0) begin : g_free
      assign gated[i] = ticks[i];
    end else begin : g_halted
      assign gated[i] = ticks[i] && !halt;
    end
  end

  assign tick_eff  = gated[sel];
  assign long_hold = (sel != SRC_4K);
endmodule

// File: rtl/rtc_tmr_count.sv
module rtc_tmr_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             event_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  logic terminal;

  assign step      = run && tick && !load;
  assign terminal  = (count == ONE) || (count == '0);
  assign event_out = step && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (load)     count <= preset;
    else if (step) begin
      if (terminal)    count <= preset;
      else             count <= count - ONE;
    end
  end
endmodule

// File: rtl/rtc_tmr_irq.sv
module rtc_tmr_irq #(
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic long_in,
  input  logic tick_4k,
  output logic irq_oe,
  output logic irq_lvl
);
  localparam int HOLD_W = $clog2(LONG_TICKS + 1) + 1;
  localparam logic [HOLD_W-1:0] LIM_S = HOLD_W'(SHORT_TICKS);
  localparam logic [HOLD_W-1:0] LIM_L = HOLD_W'(LONG_TICKS);

  logic              active;
  logic              is_long;
  logic [HOLD_W-1:0] hold;
  logic [HOLD_W-1:0] lim;
  logic [HOLD_W-1:0] hold_nx;

  assign lim     = is_long ? LIM_L : LIM_S;
  assign hold_nx = hold + HOLD_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      is_long <= 1'b0;
      hold    <= '0;
    end else if (fire) begin
      active  <= 1'b1;
      is_long <= long_in;
      hold    <= '0;
    end else if (active && tick_4k) begin
      if (hold_nx == lim) begin
        active <= 1'b0;
        hold   <= '0;
      end else begin
        hold <= hold_nx;
      end
    end
  end

  assign irq_oe  = active;
  assign irq_lvl = !active;
endmodule

// File: rtl/rtc_cycle_timer.sv
module rtc_cycle_timer
  import rtc_tmr_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int DATA_W      = 8,
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_4k,
  input  logic              tick_64,
  input  logic              tick_sec,
  input  logic              tick_min,
  input  logic              halt,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_oe,
  output logic              irq_lvl
);
  logic [CNT_W-1:0] preset;
  logic [CNT_W-1:0] count;
  logic [1:0]       sel;
  logic             en, ie, flag, en_rise;
  logic             tick_eff, long_hold, ev_w;
  logic [3:0]       ticks;

  assign ticks = {tick_min, tick_sec, tick_64, tick_4k};

  rtc_tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .event_in(ev_w), .preset(preset), .sel(sel), .en(en), .ie(ie),
    .flag(flag), .en_rise(en_rise), .rdata(reg_rdata)
  );

  rtc_tmr_src #(.N_SRC(4)) u_src (
    .ticks(ticks), .sel(sel), .halt(halt),
    .tick_eff(tick_eff), .long_hold(long_hold)
  );

  rtc_tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .load(en_rise), .run(en), .tick(tick_eff),
    .preset(preset), .count(count), .event_out(ev_w)
  );

  rtc_tmr_irq #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_irq (
    .clk(clk), .rst(rst), .fire(ev_w && ie), .long_in(long_hold),
    .tick_4k(tick_4k), .irq_oe(irq_oe), .irq_lvl(irq_lvl)
  );
endmodule

// File: rtl/rtc_cycle_timer_chk.sv
module rtc_cycle_timer_chk #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_w,
  input logic              ie,
  input logic              flag,
  input logic              en_rise,
  input logic              halt,
  input logic [1:0]        sel,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  preset,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_oe
);
  a_r6_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
    ev_w |=> flag);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    flag && !(reg_wr && reg_addr == 2'd3 && !reg_wdata[0]) |=> flag);

  a_r7_irq_follows_event: assert property (@(posedge clk) disable iff (rst)
    ev_w && ie |=> irq_oe);

  a_r5_rise_loads: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> count == $past(preset));

  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halt && sel != 2'd0 && !en_rise |=> $stable(count));

  a_r9_halt_no_event: assert property (@(posedge clk) disable iff (rst)
    halt && sel != 2'd0 |-> !ev_w);

  a_r2_hi_upper_zero: assert property (@(posedge clk) disable iff (rst)
    reg_addr == 2'd1 |=> reg_rdata[DATA_W-1:4] == '0);
endmodule

bind rtc_cycle_timer rtc_cycle_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ev_w(ev_w), .ie(ie), .flag(flag), .en_rise(en_rise),
  .halt(halt), .sel(sel), .count(count), .preset(preset), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_oe(irq_oe)
);

// File: tb/rtc_cycle_timer_bench.sv
module rtc_cycle_timer_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_4k = 0, tick_64 = 0, tick_sec = 0, tick_min = 0, halt = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 2'd3;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq_oe, irq_lvl;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_pre, m_sel, m_cnt, m_hold, m_len, m_rd;
  bit m_en, m_ie, m_flag, m_act;

  always #(CLK_P/2) clk = ~clk;

  rtc_cycle_timer u_rtc_cycle_timer (
    .clk(clk), .rst(rst), .tick_4k(tick_4k), .tick_64(tick_64),
    .tick_sec(tick_sec), .tick_min(tick_min), .halt(halt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_oe(irq_oe), .irq_lvl(irq_lvl)
  );

  // tick strobes: rates drift against each other
  always @(negedge clk) begin
    cyc++;
    tick_4k  <= (cyc % 3) == 0;
    tick_64  <= (cyc % 5) == 0;
    tick_sec <= (cyc % 7) == 0;
    tick_min <= (cyc % 13) == 0;
  end

  always @(posedge clk) begin
    bit tk, ev, rise;
    int nrd;
    if (rst) begin
      m_pre = 0; m_sel = 0; m_cnt = 0; m_hold = 0; m_len = 1; m_rd = 0;
      m_en = 0; m_ie = 0; m_flag = 0; m_act = 0;
    end else begin
      case (m_sel)
        0: tk = tick_4k;
        1: tk = tick_64;
        2: tk = tick_sec;
        default: tk = tick_min;
      endcase
      if (halt && m_sel != 0) tk = 0;
      rise = reg_wr && reg_addr == 2 && reg_wdata[4] && !m_en;
      ev = 0;
      if (rise) m_cnt = m_pre;
      else if (m_en && tk) begin
        if (m_cnt == 1) begin ev = 1; m_cnt = m_pre; end
        else if (m_cnt == 0) m_cnt = m_pre;
        else m_cnt = m_cnt - 1;
      end
      if (ev && m_ie) begin
        m_act = 1; m_hold = 0; m_len = (m_sel == 0) ? 1 : 32;
      end else if (m_act && tick_4k) begin
        if (m_hold + 1 == m_len) begin m_act = 0; m_hold = 0; end
        else m_hold = m_hold + 1;
      end
      case (reg_addr)
        0: nrd = m_pre & 8'hFF;
        1: nrd = (m_pre >> 8) & 4'hF;
        2: nrd = m_sel | (int'(m_en) << 4) | (int'(m_ie) << 5);
        default: nrd = int'(m_flag);
      endcase
      m_rd = nrd;
      if (ev) m_flag = 1;
      else if (reg_wr && reg_addr == 3 && !reg_wdata[0]) m_flag = 0;
      if (reg_wr) begin
        case (reg_addr)
          0: m_pre = (m_pre & 12'hF00) | reg_wdata;
          1: m_pre = (m_pre & 8'hFF) | ((reg_wdata & 4'hF) << 8);
          2: begin m_sel = reg_wdata & 3; m_en = reg_wdata[4]; m_ie = reg_wdata[5]; end
          default: ;
        endcase
      end
    end
    started = 1;
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (reg_rdata !== 8'(m_rd)) begin
        n_bad++;
        $display("FAIL %s: reg_rdata act=%h exp=%h (cycle %0d)", cur_req, reg_rdata, 8'(m_rd), cyc);
      end
      n_cmp++;
      if (irq_oe !== m_act || irq_lvl !== !m_act) begin
        n_bad++;
        $display("FAIL %s: irq oe/lvl act=%b/%b exp=%b/%b (cycle %0d)", cur_req,
                 irq_oe, irq_lvl, m_act, !m_act, cyc);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 0; reg_addr = 2'd3;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 2'd3;
  endtask

  // explicit read check against a value fixed by the requirements
  task automatic chk_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_wr = 0; reg_addr = a;
    @(negedge clk);
    n_cmp++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: read addr %0d act=%h exp=%h", req, a, reg_rdata, exp);
    end
    reg_addr = 2'd3;
  endtask

  task automatic run_with_clears(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_addr = 2'd3;
      reg_wdata = 8'h00;
      reg_wr = (i % every) == 0;
    end
    @(negedge clk);
    reg_wr = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset values
    cur_req = "R1";
    chk_rd(2'd0, 8'h00, "R1");
    chk_rd(2'd1, 8'h00, "R1");
    chk_rd(2'd2, 8'h00, "R1");
    chk_rd(2'd3, 8'h00, "R1");

    // R2: register layout and upper nibble zero
    cur_req = "R2";
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'hF7);
    chk_rd(2'd1, 8'h07, "R2");
    chk_rd(2'd0, 8'hA5, "R2");
    wr(2'd2, 8'hC2);
    chk_rd(2'd2, 8'h02, "R2");

    // R4 / R7 / R8: 4096 Hz source, short hold
    cur_req = "R4";
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h30);
    idle(80);
    // R6: writing 1 leaves the flag set
    cur_req = "R6";
    wr(2'd3, 8'h01);
    chk_rd(2'd3, 8'h01, "R6");
    run_with_clears(150, 4);

    // R3 / R8: 64 Hz source with long hold; clear does not release
    cur_req = "R8";
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h31);
    run_with_clears(600, 3);

    // R3 / R9: seconds source, halted then released
    cur_req = "R9";
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h32);
    idle(60);
    halt = 1;
    idle(200);
    halt = 0;
    idle(200);

    // R3: minutes source
    cur_req = "R3";
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h33);
    run_with_clears(500, 5);

    // R9: halt leaves the 4096 Hz source running
    cur_req = "R9";
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h30);
    halt = 1;
    idle(150);
    halt = 0;

    // R5: stop freezes count, re-enable reloads the preset
    cur_req = "R5";
    wr(2'd2, 8'h20);
    idle(40);
    wr(2'd0, 8'h05);
    wr(2'd2, 8'h30);
    idle(120);

    // R7: interrupt enable off, flag still set
    cur_req = "R7";
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h10);
    idle(100);
    chk_rd(2'd3, 8'h01, "R7");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule